// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a small synchronous pipelined burst SRAM: by default 64 words of 36 bits, held as four 9-bit byte lanes. Address, strobes, chip enables, write enables and write data are captured on the rising clock edge. A new cycle begins on either of two address strobes, one from a processor and one from a cache controller. After that, a 2-bit beat counter produces the two low address bits of each later beat while the advance input is held low. The upper address bits stay as they were loaded. A static order input chooses a linear or an interleaved beat sequence.

Reads are pipelined. The captured address is read on the next edge into an output register, so data reaches the bus one clock after the address was taken. Writes go to the array on the edge after capture. The output enable and the sleep input act on the bus drive at once, without waiting for a clock edge. The bus is shown as a data output plus a drive flag: while the flag is low, the data output reads zero and the bus counts as high impedance.

Top module: `burst_sram`

## Requirements
- R1: A read captured on edge k puts the word on `dout` with `dq_drive` high after edge k+1, provided `oe_n` is low and `sleep` is low.
- R2: When `ce1_n` is high, `proc_strobe_n` is ignored. A burst already running continues as if the strobe were absent. The controller strobe is still taken, and with `ce1_n` high it ends the burst.
- R3: A strobe starts a new cycle only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe seen while any of these is inactive deselects the device: nothing is written, nothing is read, and later advance cycles do nothing until the next valid start.
- R4: When both strobes are low on one edge and the processor strobe is not blocked, the processor strobe wins. A cycle started by the processor strobe is always a read, whatever the write enables are.
- R5: During a burst, `adv_n`=0 on an edge moves to the next beat. `adv_n`=1 repeats the current address.
- R6: With `order_linear`=1, the low two address bits of beat n are (start+n) mod 4, and the upper bits stay fixed (start 1 gives 1,2,3,0).
- R7: With `order_linear`=0, the low two bits of beat n are start XOR n (start 1 gives 1,0,3,2).
- R8: `wr_all_n`=0 writes all four lanes, whatever `wr_byte_n` and `lane_we_n` are.
- R9: With `wr_all_n`=1 and `wr_byte_n`=0, only lane i with `lane_we_n[i]`=0 is written. Lane i is bits [9i+8:9i]. With both at 1 the cycle is a read, and `lane_we_n` alone writes nothing.
- R10: With `sleep` high, no read or write takes place on an edge. Pending work and the burst are dropped, and `dq_drive` falls immediately.
- R11: `oe_n` high forces `dq_drive` low at once. `oe_n` low restores it, with the held data, without a clock edge.
- R12: After reset `dq_drive` is low, `dout` is zero, and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address loaded on a start |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by `ce1_n` |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Global full-width write, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| order_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dq_drive | output | 1 | High when the data bus is driven |

## Verification
The assertions watch, on every edge, that a blocked processor strobe never starts a cycle and that no start happens without all three enables. They also check that a processor start is captured as a read, that a held burst keeps its address, that a step keeps the upper bits, that a captured read produces valid data one edge later, and that sleep clears both the pending operation and the output register. The bench scenarios are the only place where data values appear. Only they show the linear and interleaved beat sequences, the lane merge of byte writes, writes suppressed by deselect or sleep, and the immediate effect of `oe_n` and `sleep` between clock edges.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_t;

  // Low two address bits of a beat: linear adds, interleaved XORs.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] beat,
                                           input logic       linear);
    return linear ? (base + beat) : (base ^ beat);
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sleep,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       proc_strobe_n,
  input  logic                       ctrl_strobe_n,
  input  logic                       adv_n,
  input  logic                       ce1_n,
  input  logic                       ce2,
  input  logic                       ce3_n,
  input  logic                       wr_all_n,
  input  logic                       wr_byte_n,
  input  logic [LANES-1:0]           lane_we_n,
  input  logic                       order_linear,
  input  logic [LANES*LANE_W-1:0]    din,
  output logic                       start_proc,
  output logic                       start_ctrl,
  output logic                       step,
  output logic                       burst_active,
  output op_t                        op_q,
  output logic [ADDR_W-1:0]          addr_q,
  output logic [LANES-1:0]           wmask_q,
  output logic [LANES*LANE_W-1:0]    din_q
);
  localparam int UPPER_W = ADDR_W - 2;

  logic               ce_ok, proc_seen, ctrl_seen, deselect, cont;
  logic               active_q;
  logic [UPPER_W-1:0] upper_q;
  logic [1:0]         base_q, beat_q, next_beat;
  logic [ADDR_W-1:0]  cont_addr;
  logic [LANES-1:0]   wmask_in;

  assign ce_ok      = !ce1_n && ce2 && !ce3_n;
  assign proc_seen  = !proc_strobe_n && !ce1_n;
  assign ctrl_seen  = !ctrl_strobe_n && !proc_seen;
  assign start_proc = !sleep && proc_seen && ce_ok;
  assign start_ctrl = !sleep && ctrl_seen && ce_ok;
  assign deselect   = !sleep && (proc_seen || ctrl_seen) && !ce_ok;
  assign cont       = !sleep && !(proc_seen || ctrl_seen) && active_q;
  assign step       = cont && !adv_n;
  assign burst_active = active_q;

  assign next_beat = step ? beat_q + 2'd1 : beat_q;
  assign cont_addr = {upper_q, burst_low(base_q, next_beat, order_linear)};

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign wmask_in[i] = !wr_all_n || (!wr_byte_n && !lane_we_n[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      upper_q  <= '0;
      base_q   <= 2'd0;
      beat_q   <= 2'd0;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      wmask_q  <= '0;
      din_q    <= '0;
    end else begin
      din_q   <= din;
      op_q    <= OP_NONE;
      wmask_q <= '0;
      if (start_proc || start_ctrl) begin
        active_q <= 1'b1;
        upper_q  <= addr[ADDR_W-1:2];
        base_q   <= addr[1:0];
        beat_q   <= 2'd0;
        addr_q   <= addr;
        if (start_proc) begin
          op_q <= OP_READ;
        end else begin
          op_q    <= (|wmask_in) ? OP_WRITE : OP_READ;
          wmask_q <= wmask_in;
        end
      end else if (cont) begin
        beat_q  <= next_beat;
        addr_q  <= cont_addr;
        op_q    <= (|wmask_in) ? OP_WRITE : OP_READ;
        wmask_q <= wmask_in;
      end else if (sleep || deselect) begin
        active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  op_t                     op_q,
  input  logic [ADDR_W-1:0]       addr_q,
  input  logic [LANES-1:0]        wmask_q,
  input  logic [LANES*LANE_W-1:0] din_q,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic do_write, do_read;
  assign do_write = !sleep && (op_q == OP_WRITE);
  assign do_read  = !sleep && (op_q == OP_READ);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];
      logic [LANE_W-1:0] rd_lane;

      always_ff @(posedge clk) begin
        if (do_write && wmask_q[i]) lane_mem[addr_q] <= din_q[i*LANE_W +: LANE_W];
        if (do_read) rd_lane <= lane_mem[addr_q];
      end

      assign rd_data[i*LANE_W +: LANE_W] = rd_lane;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= do_read;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    order_linear,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dq_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              start_proc, start_ctrl, step, burst_active, rd_valid;
  op_t               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  wmask_q;
  logic [DATA_W-1:0] din_q, rd_data;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_we_n(lane_we_n),
    .order_linear(order_linear), .din(din),
    .start_proc(start_proc), .start_ctrl(start_ctrl), .step(step),
    .burst_active(burst_active), .op_q(op_q), .addr_q(addr_q),
    .wmask_q(wmask_q), .din_q(din_q)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .op_q(op_q), .addr_q(addr_q),
    .wmask_q(wmask_q), .din_q(din_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Bus drive reacts to oe_n and sleep without a clock edge.
  assign dq_drive = rd_valid && !oe_n && !sleep;
  assign dout     = dq_drive ? rd_data : '0;

endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              start_proc,
  input logic              start_ctrl,
  input logic              step,
  input logic              burst_active,
  input op_t               op_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [LANES-1:0]  wmask_q,
  input logic              rd_valid
);

  p_read_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_READ && !sleep) |=> rd_valid);

  p_proc_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && ce1_n) |-> !start_proc);

  p_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_proc || start_ctrl) |-> (!ce1_n && ce2 && !ce3_n));

  p_proc_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_proc |=> (op_q == OP_READ && wmask_q == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !sleep && adv_n && proc_strobe_n && ctrl_strobe_n) |=> $stable(addr_q));

  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

  p_sleep_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!rd_valid && op_q == OP_NONE));

endmodule

bind burst_sram burst_sram_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep),
  .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .start_proc(start_proc), .start_ctrl(start_ctrl), .step(step),
  .burst_active(burst_active), .op_q(op_q), .addr_q(addr_q),
  .wmask_q(wmask_q), .rd_valid(rd_valid)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, adv_n = 1'b1;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [NL-1:0] lane_we_n = '1;
  logic          order_linear = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dq_drive;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_we_n(lane_we_n),
    .order_linear(order_linear), .oe_n(oe_n), .sleep(sleep), .din(din),
    .dout(dout), .dq_drive(dq_drive)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int            due;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [DW-1:0] model [1<<AW];

  function automatic logic [DW-1:0] pat(input int i);
    return {4'hA, 32'(i) * 32'h0103_0507 + 32'h0000_1111};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; returns at the next falling edge.
  task automatic drive(input logic ps, input logic cs, input logic adv,
                       input logic [AW-1:0] a, input logic ga, input logic gb,
                       input logic [NL-1:0] lw, input logic [DW-1:0] d);
    proc_strobe_n = ps; ctrl_strobe_n = cs; adv_n = adv;
    addr = a; wr_all_n = ga; wr_byte_n = gb; lane_we_n = lw; din = d;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1, 1, 1, '0, 1, 1, '1, '0);
  endtask

  // Read of the cycle now being driven shows up two falling edges later.
  task automatic expect_rd(input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.due = cyc + 2; e.data = d; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic quiet(input string tag);
    check(!dq_drive, tag, {35'd0, dq_drive}, '0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(dq_drive && dout == e.data, e.tag, dout, e.data);
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q;
    @(negedge clk); @(negedge clk);
    // R12: reset state
    quiet("R12 drive after reset");
    check(dout == '0, "R12 dout after reset", dout, '0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1, 1, 0, '0, 1, 1, '1, '0);
    drive(1, 1, 0, '0, 1, 1, '1, '0);
    quiet("R12 no burst after reset");

    // R8/R5/R6: controller-started full write burst at 8..11 (linear)
    for (int i = 0; i < 4; i++) begin
      model[8+i] = pat(i);
      if (i == 0) drive(1, 0, 1, 6'd8, 0, 1, '1, pat(i));
      else        drive(1, 1, 0, '0, 0, 1, '1, pat(i));
    end
    model[30] = pat(30); model[31] = pat(31);
    drive(1, 0, 1, 6'd30, 0, 0, 4'b0000, pat(30)); // R8: all lanes
    drive(1, 1, 0, '0, 0, 1, '1, pat(31));
    idle();

    // R6/R1: processor read, linear from 9: 9,10,11,8
    expect_rd(model[9],  "R1 linear beat0");
    drive(0, 1, 1, 6'd9, 0, 0, 4'b0000, '1);  // R4 write enables ignored
    expect_rd(model[10], "R6 linear beat1");  drive(1, 1, 0, '0, 1, 1, 4'b0000, '0);
    expect_rd(model[11], "R6 linear beat2");  drive(1, 1, 0, '0, 1, 1, 4'b0000, '0);
    expect_rd(model[8],  "R6 linear wrap");   drive(1, 1, 0, '0, 1, 1, 4'b0000, '0);
    idle(); idle();

    // R7: interleaved from 9: 9,8,11,10
    order_linear = 1'b0;
    expect_rd(model[9],  "R7 inter beat0");   drive(0, 1, 1, 6'd9, 1, 1, '1, '0);
    expect_rd(model[8],  "R7 inter beat1");   drive(1, 1, 0, '0, 1, 1, '1, '0);
    expect_rd(model[11], "R7 inter beat2");   drive(1, 1, 0, '0, 1, 1, '1, '0);
    expect_rd(model[10], "R7 inter beat3");   drive(1, 1, 0, '0, 1, 1, '1, '0);
    idle(); idle();
    order_linear = 1'b1;

    // R5: hold then step
    expect_rd(model[8], "R5 start");          drive(0, 1, 1, 6'd8, 1, 1, '1, '0);
    expect_rd(model[8], "R5 hold repeats");   drive(1, 1, 1, '0, 1, 1, '1, '0);
    expect_rd(model[9], "R5 step");           drive(1, 1, 0, '0, 1, 1, '1, '0);
    idle(); idle();

    // R4: both strobes with write enables -> read of 8, no write
    expect_rd(model[8], "R4 proc priority read"); drive(0, 0, 1, 6'd8, 0, 0, 4'b0000, '0);
    idle(); idle();
    expect_rd(model[8], "R4 no write happened");  drive(1, 0, 1, 6'd8, 1, 1, '1, '0);
    idle(); idle();

    // R2: blocked processor strobe does not disturb a running burst
    expect_rd(model[8], "R2 burst start");    drive(0, 1, 1, 6'd8, 1, 1, '1, '0);
    ce1_n = 1'b1;
    expect_rd(model[9], "R2 blocked strobe ignored"); drive(0, 1, 0, 6'd40, 1, 1, '1, '0);
    ce1_n = 1'b0;
    idle(); idle();

    // R3: deselect by ce2 low; no write, burst ends
    ce2 = 1'b0;
    drive(1, 0, 1, 6'd30, 0, 1, '1, pat(99));
    ce2 = 1'b1;
    drive(1, 1, 0, '0, 0, 1, '1, pat(98));
    drive(1, 1, 0, '0, 1, 1, '1, '0);
    quiet("R3 deselect no output");
    // R2/R3: controller strobe with ce1_n high ends a burst
    drive(0, 1, 1, 6'd8, 1, 1, '1, '0);
    ce1_n = 1'b1;
    drive(1, 0, 1, 6'd8, 1, 1, '1, '0);
    ce1_n = 1'b0;
    drive(1, 1, 0, '0, 1, 1, '1, '0);
    drive(1, 1, 0, '0, 1, 1, '1, '0);
    quiet("R2 ctrl strobe with ce1_n high deselects");
    expect_rd(model[30], "R3 addr30 unchanged"); drive(1, 0, 1, 6'd30, 1, 1, '1, '0);
    expect_rd(model[31], "R3 addr31 unchanged"); drive(1, 1, 0, '0, 1, 1, '1, '0);
    idle(); idle();

    // R9: byte lanes 0 and 2 at 20; R8: global wins at 21
    model[20] = pat(20);
    drive(1, 0, 1, 6'd20, 0, 1, '1, pat(20));
    q = pat(77);
    model[20][0*LW +: LW] = q[0*LW +: LW];
    model[20][2*LW +: LW] = q[2*LW +: LW];
    drive(1, 0, 1, 6'd20, 1, 0, 4'b1010, q);
    model[21] = pat(21);
    drive(1, 1, 0, '0, 0, 0, 4'b1110, pat(21));
    idle();
    expect_rd(model[20], "R9 lane merge");    drive(1, 0, 1, 6'd20, 1, 1, 4'b0000, pat(55));
    expect_rd(model[21], "R8 global full");   drive(1, 1, 0, '0, 1, 1, 4'b0000, pat(55));
    idle(); idle();

    // R10: sleep drops a pending read and blocks a write
    drive(1, 0, 1, 6'd8, 1, 1, '1, '0);
    sleep = 1'b1;
    idle();
    quiet("R10 pending read dropped");
    drive(1, 0, 1, 6'd8, 0, 1, '1, pat(66));
    sleep = 1'b0;
    idle();
    quiet("R10 no output after sleep");
    expect_rd(model[8], "R10 no write in sleep"); drive(1, 0, 1, 6'd8, 1, 1, '1, '0);
    idle();
    // R10 / R11: asynchronous bus control while data is held
    #1 sleep = 1'b1;
    #1 quiet("R10 sleep async");
    sleep = 1'b0;
    #1 oe_n = 1'b1;
    #1 quiet("R11 oe_n async off");
    oe_n = 1'b0;
    #1 check(dq_drive && dout == model[8], "R11 oe_n async on", dout, model[8]);
    @(negedge clk);
    idle(); idle();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule